// File: doc/BRIEF.md
# Vector integer extension unit

This block widens narrow integer elements into elements of the current element width (SEW), either by zero-filling or by sign-filling the new upper bits. The widening factor is 2, 4 or 8, so a source element is SEW/2, SEW/4 or SEW/8 bits wide. A request carries the fill mode, the factor, SEW, the group multiplier (LMUL), the destination and source register indices, and the element count `vl`.

Before any work starts the request is checked for legality. The checks cover the SEW against the factor, the source group multiplier, and the alignment of both register indices. Every failing check is ORed into one illegal flag. A legal request is carried out one element per cycle. Each element is read from a packed source buffer through a word address and a 64-bit word input. Each widened result leaves on a registered result port together with its element index.

Top module: `vext_unit`

## Requirements
- R1: Source element i, of width w = SEW/factor, is taken from bits [i*w mod 64 +: w] of source word (i*w)/64. The unit presents that word address on `src_addr` and reads the word on `src_word`.
- R2: With `req_sign` = 0 the bits above the source width are filled with zeros, so an 8-bit 0xFD widened reads 253.
- R3: With `req_sign` = 1 the source sign bit is copied into the bits above the source width, so an 8-bit 0xFD widened to 16 bits reads 0xFFFD.
- R4: The factor codes are 1 = x2, 2 = x4 and 3 = x8; code 0 is illegal. The SEW codes are 0 = 8, 1 = 16, 2 = 32 and 3 = 64 bits. A request is illegal when the SEW code is below the factor code, so x8 needs SEW 64, x4 needs at least 32 and x2 needs at least 16.
- R5: The LMUL codes are 0 = 1, 1 = 2, 2 = 4, 3 = 8, 5 = 1/8, 6 = 1/4, 7 = 1/2 and 4 = reserved. The source multiplier is LMUL stepped down once per factor level along 8, 4, 2, 1, 1/2, 1/4, 1/8. A step below 1/8, or a reserved LMUL, gives a reserved source multiplier, and a reserved source multiplier makes the request illegal (this covers x2 with LMUL 1/8).
- R6: When the source multiplier is 2, 4 or 8, a source index that is not a multiple of it makes the request illegal.
- R7: When LMUL is 2, 4 or 8, a destination index that is not a multiple of it makes the request illegal.
- R8: The illegal flag is the OR of all the checks in R4 to R7. A request that fails more than one check is flagged, and a passing check never hides a failing one.
- R9: An illegal request is accepted and answered with `illegal` high for exactly the cycle after acceptance. It produces no result writes and no `done`.
- R10: A legal request produces exactly `vl` results, one per cycle, with indices 0, 1, ... in order. The first result appears two cycles after acceptance. `done` pulses in the cycle after the last result; with `vl` = 0 it pulses in the cycle after acceptance and no result is written.
- R11: `req_ready` is low while a legal request is being worked off. A request presented during that time is not taken.
- R12: While reset is held, `req_ready` is high and `res_valid`, `done` and `illegal` are low.
- R13: The bits of `res_data` above SEW are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_sign | input | 1 | 1 = sign fill, 0 = zero fill |
| req_factor | input | 2 | Widening factor code |
| req_sew | input | 2 | Element width code |
| req_lmul | input | 3 | Group multiplier code |
| req_vd | input | 5 | Destination register index |
| req_vs2 | input | 5 | Source register index |
| req_vl | input | VL_W | Number of elements |
| src_addr | output | SA_W | Word address into the packed source buffer |
| src_word | input | 64 | Source word at `src_addr` |
| res_valid | output | 1 | Result write strobe |
| res_idx | output | VL_W | Element index of the result |
| res_data | output | 64 | Widened element, SEW bits in the low end |
| illegal | output | 1 | Request rejected |
| done | output | 1 | Legal request finished |

## Verification
The sweep covers every combination of fill mode, factor code, SEW code and LMUL code with five destination and source index pairs. The pairs are aligned or misaligned so that each legality check fails alone and also together with others. The source buffer holds pseudo-random words, so roughly half the narrow elements are negative. This separates zero fill from sign fill, and checking the lane offsets at all three source widths separates the packing positions. Long runs of 64 elements cross every word boundary while a rejected request is held at the port. Runs with zero and one element test the completion timing at its edges.

// File: rtl/vext_pkg.sv
package vext_pkg;

  localparam int unsigned ELEN        = 64;
  localparam int unsigned NUM_NARROW  = 3;
  localparam int unsigned VREG_IDX_W  = 5;
  localparam int unsigned BITPOS_W    = $clog2(ELEN);

  typedef enum logic [2:0] {
    GM_1    = 3'd0,
    GM_2    = 3'd1,
    GM_4    = 3'd2,
    GM_8    = 3'd3,
    GM_RSVD = 3'd4,
    GM_F8   = 3'd5,
    GM_F4   = 3'd6,
    GM_F2   = 3'd7
  } grp_mul_e;

  // One step down the multiplier ladder; below the smallest is reserved.
  function automatic grp_mul_e mul_down(grp_mul_e m);
    case (m)
      GM_8:    mul_down = GM_4;
      GM_4:    mul_down = GM_2;
      GM_2:    mul_down = GM_1;
      GM_1:    mul_down = GM_F2;
      GM_F2:   mul_down = GM_F4;
      GM_F4:   mul_down = GM_F8;
      default: mul_down = GM_RSVD;
    endcase
  endfunction

  // Low index bits that must be zero for a register group of this size.
  function automatic logic [VREG_IDX_W-1:0] align_bits(grp_mul_e m);
    case (m)
      GM_2:    align_bits = VREG_IDX_W'(1);
      GM_4:    align_bits = VREG_IDX_W'(3);
      GM_8:    align_bits = VREG_IDX_W'(7);
      default: align_bits = '0;
    endcase
  endfunction

  function automatic logic [ELEN-1:0] sew_keep(logic [1:0] sew);
    case (sew)
      2'd0:    sew_keep = ELEN'(64'h0000_0000_0000_00FF);
      2'd1:    sew_keep = ELEN'(64'h0000_0000_0000_FFFF);
      2'd2:    sew_keep = ELEN'(64'h0000_0000_FFFF_FFFF);
      default: sew_keep = '1;
    endcase
  endfunction

endpackage

// File: rtl/vext_legal.sv
module vext_legal
  import vext_pkg::*;
(
  input  logic [1:0]            factor,
  input  logic [1:0]            sew,
  input  logic [2:0]            lmul,
  input  logic [VREG_IDX_W-1:0] vd,
  input  logic [VREG_IDX_W-1:0] vs2,
  output logic                  bad
);

  grp_mul_e dst_mul;
  grp_mul_e src_mul;
  logic     bad_factor, bad_sew, bad_src_mul, bad_src_align, bad_dst_align;

  assign dst_mul = grp_mul_e'(lmul);

  // Step the multiplier down once per factor level.
  always_comb begin
    src_mul = dst_mul;
    for (int k = 0; k < 3; k++) begin
      if (k < int'(factor)) src_mul = mul_down(src_mul);
    end
  end

  assign bad_factor    = (factor == 2'd0);
  assign bad_sew       = (sew < factor);
  assign bad_src_mul   = (src_mul == GM_RSVD);
  assign bad_src_align = |(vs2 & align_bits(src_mul));
  assign bad_dst_align = |(vd & align_bits(dst_mul));

  // Every check accumulates; none can clear another.
  assign bad = bad_factor | bad_sew | bad_src_mul | bad_src_align | bad_dst_align;

endmodule

// File: rtl/vext_lane.sv
module vext_lane
  import vext_pkg::*;
#(
  parameter int unsigned CNT_W = 7,
  parameter int unsigned SA_W  = 6
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [1:0]       wsel,
  input  logic             sign,
  input  logic [1:0]       sew,
  input  logic [ELEN-1:0]  src_word,
  output logic [SA_W-1:0]  src_addr,
  output logic [ELEN-1:0]  ext_data
);

  logic [ELEN-1:0] cand   [NUM_NARROW];
  logic [SA_W-1:0] addr_c [NUM_NARROW];
  logic [ELEN-1:0] picked;

  for (genvar g = 0; g < NUM_NARROW; g++) begin : g_width
    localparam int unsigned W   = 8 << g;
    localparam int unsigned PER = ELEN / W;
    localparam int unsigned SH  = $clog2(PER);

    logic [SH-1:0]       lane;
    logic [BITPOS_W-1:0] bitpos;
    logic [W-1:0]        narrow;

    assign lane      = cnt[SH-1:0];
    assign bitpos    = BITPOS_W'(lane) << (3 + g);
    assign addr_c[g] = SA_W'(cnt >> SH);
    assign narrow    = src_word[bitpos +: W];
    assign cand[g]   = {{(ELEN-W){sign & narrow[W-1]}}, narrow};
  end

  always_comb begin
    src_addr = addr_c[0];
    picked   = cand[0];
    case (wsel)
      2'd1: begin src_addr = addr_c[1]; picked = cand[1]; end
      2'd2: begin src_addr = addr_c[2]; picked = cand[2]; end
      default: ;
    endcase
  end

  assign ext_data = picked & sew_keep(sew);

endmodule

// File: rtl/vext_unit.sv
module vext_unit
  import vext_pkg::*;
#(
  parameter  int unsigned MAX_VL = 64,
  localparam int unsigned VL_W   = $clog2(MAX_VL + 1),
  localparam int unsigned SA_W   = $clog2(MAX_VL)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_sign,
  input  logic [1:0]            req_factor,
  input  logic [1:0]            req_sew,
  input  logic [2:0]            req_lmul,
  input  logic [VREG_IDX_W-1:0] req_vd,
  input  logic [VREG_IDX_W-1:0] req_vs2,
  input  logic [VL_W-1:0]       req_vl,
  output logic [SA_W-1:0]       src_addr,
  input  logic [ELEN-1:0]       src_word,
  output logic                  res_valid,
  output logic [VL_W-1:0]       res_idx,
  output logic [ELEN-1:0]       res_data,
  output logic                  illegal,
  output logic                  done
);

  logic            busy_q;
  logic [VL_W-1:0] cnt_q;
  logic [VL_W-1:0] vl_q;
  logic            sign_q;
  logic [1:0]      sew_q;
  logic [1:0]      wsel_q;
  logic            last_q;
  logic            req_bad;
  logic            accept;
  logic [ELEN-1:0] ext_data;

  vext_legal u_legal (
    .factor (req_factor),
    .sew    (req_sew),
    .lmul   (req_lmul),
    .vd     (req_vd),
    .vs2    (req_vs2),
    .bad    (req_bad)
  );

  vext_lane #(
    .CNT_W (VL_W),
    .SA_W  (SA_W)
  ) u_lane (
    .cnt      (cnt_q),
    .wsel     (wsel_q),
    .sign     (sign_q),
    .sew      (sew_q),
    .src_word (src_word),
    .src_addr (src_addr),
    .ext_data (ext_data)
  );

  assign req_ready = !busy_q;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      cnt_q     <= '0;
      vl_q      <= '0;
      sign_q    <= 1'b0;
      sew_q     <= '0;
      wsel_q    <= '0;
      last_q    <= 1'b0;
      res_valid <= 1'b0;
      res_idx   <= '0;
      res_data  <= '0;
      illegal   <= 1'b0;
      done      <= 1'b0;
    end else begin
      illegal   <= 1'b0;
      res_valid <= 1'b0;
      last_q    <= 1'b0;
      done      <= res_valid && last_q;
      if (accept) begin
        if (req_bad) begin
          illegal <= 1'b1;
        end else if (req_vl == '0) begin
          done <= 1'b1;
        end else begin
          busy_q <= 1'b1;
          cnt_q  <= '0;
          vl_q   <= req_vl;
          sign_q <= req_sign;
          sew_q  <= req_sew;
          wsel_q <= req_sew - req_factor;
        end
      end else if (busy_q) begin
        res_valid <= 1'b1;
        res_idx   <= cnt_q;
        res_data  <= ext_data;
        cnt_q     <= cnt_q + 1'b1;
        if (cnt_q == vl_q - 1'b1) begin
          busy_q <= 1'b0;
          last_q <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/vext_unit_chk.sv
module vext_unit_chk #(
  parameter int unsigned VL_W = 7
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_ready,
  input logic [1:0]      req_sew,
  input logic            res_valid,
  input logic [VL_W-1:0] res_idx,
  input logic [63:0]     res_data,
  input logic            illegal,
  input logic            done
);

  logic [1:0] sew_l;

  always_ff @(posedge clk) begin
    if (rst) sew_l <= '0;
    else if (req_valid && req_ready) sew_l <= req_sew;
  end

  a_r9_illegal_silent: assert property (@(posedge clk) disable iff (rst)
    illegal |-> !res_valid);

  a_r10_index_order: assert property (@(posedge clk) disable iff (rst)
    (res_valid && $past(res_valid)) |-> (res_idx == $past(res_idx) + 1'b1));

  a_r10_first_gap: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !res_valid);

  a_r10_done_quiet: assert property (@(posedge clk) disable iff (rst)
    done |-> !res_valid);

  a_r11_ready_drop: assert property (@(posedge clk) disable iff (rst)
    $fell(req_ready) |-> $past(req_valid));

  a_r13_upper_zero: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> ((res_data >> (8 << sew_l)) == 64'd0));

endmodule

bind vext_unit vext_unit_chk #(.VL_W(VL_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_sew   (req_sew),
  .res_valid (res_valid),
  .res_idx   (res_idx),
  .res_data  (res_data),
  .illegal   (illegal),
  .done      (done)
);

// File: tb/vext_unit_tb.sv
module vext_unit_tb;

  localparam int MAX_VL = 64;
  localparam int VL_W   = $clog2(MAX_VL + 1);
  localparam int SA_W   = $clog2(MAX_VL);

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic            req_sign = 1'b0;
  logic [1:0]      req_factor = '0;
  logic [1:0]      req_sew = '0;
  logic [2:0]      req_lmul = '0;
  logic [4:0]      req_vd = '0;
  logic [4:0]      req_vs2 = '0;
  logic [VL_W-1:0] req_vl = '0;
  logic [SA_W-1:0] src_addr;
  logic [63:0]     src_word;
  logic            res_valid;
  logic [VL_W-1:0] res_idx;
  logic [63:0]     res_data;
  logic            illegal;
  logic            done;

  logic [63:0] mem [64];
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  assign src_word = mem[src_addr];

  vext_unit #(.MAX_VL(MAX_VL)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_sign(req_sign), .req_factor(req_factor), .req_sew(req_sew),
    .req_lmul(req_lmul), .req_vd(req_vd), .req_vs2(req_vs2), .req_vl(req_vl),
    .src_addr(src_addr), .src_word(src_word), .res_valid(res_valid),
    .res_idx(res_idx), .res_data(res_data), .illegal(illegal), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic run_case(input bit sg, input int f, input int s, input int l,
                          input int vd, input int vs2, input int vl, input bit poke);
    int causes, lg, sl, w, wi, off;
    string tag, dtag;
    logic [63:0] raw, nmask, smask, ev;
    causes = 0;
    tag = "R8";
    lg = (l == 4) ? -4 : ((l < 4) ? l : l - 8);
    sl = lg - f;
    if (f == 0 || s < f) begin causes++; tag = "R4"; end
    if (lg == -4 || sl < -3) begin causes++; tag = "R5"; end
    if (sl > 0 && (vs2 % (1 << sl)) != 0) begin causes++; tag = "R6"; end
    if (lg > 0 && (vd % (1 << lg)) != 0) begin causes++; tag = "R7"; end
    if (causes > 1) tag = "R8";

    @(negedge clk);
    req_sign = sg; req_factor = 2'(f); req_sew = 2'(s); req_lmul = 3'(l);
    req_vd = 5'(vd); req_vs2 = 5'(vs2); req_vl = VL_W'(vl);
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;

    if (causes != 0) begin
      chk(illegal == 1'b1, tag, "illegal flag", 64'(illegal), 64'd1);
      chk(!res_valid && !done, "R9", "write or done on rejected request",
          {res_valid, done}, 64'd0);
      @(posedge clk); @(negedge clk);
      chk(!illegal && !res_valid, "R9", "illegal pulse length", {illegal, res_valid}, 64'd0);
      return;
    end

    chk(illegal == 1'b0, tag, "legal request flagged", 64'(illegal), 64'd0);
    if (vl == 0) begin
      chk(done && !res_valid, "R10", "empty request done", {done, res_valid}, 64'b10);
      return;
    end
    chk(!res_valid && !done, "R10", "no result in acceptance cycle", {res_valid, done}, 64'd0);

    if (poke) begin
      req_factor = 2'd0;
      req_valid  = (vl >= 2);
    end
    w = 8 << (s - f);
    nmask = (64'd1 << w) - 64'd1;
    smask = (s == 3) ? '1 : ((64'd1 << (8 << s)) - 64'd1);
    dtag = sg ? "R3/R13" : "R2/R13";
    for (int k = 0; k < vl; k++) begin
      @(posedge clk); @(negedge clk);
      wi  = (k * w) / 64;
      off = (k * w) % 64;
      raw = (mem[wi] >> off) & nmask;
      if (sg && raw[w-1]) raw = raw | ~nmask;
      ev = raw & smask;
      chk(res_valid == 1'b1, "R10", "result strobe", 64'(res_valid), 64'd1);
      chk(res_idx == VL_W'(k), "R10", "result index", 64'(res_idx), 64'(k));
      chk(res_data == ev, dtag, "widened value (R1 placement)", res_data, ev);
      chk(req_ready == (k == vl - 1), "R11", "ready while working",
          64'(req_ready), 64'(k == vl - 1));
      if (poke) begin
        chk(illegal == 1'b0, "R11", "request taken while busy", 64'(illegal), 64'd0);
        req_valid = (k + 1 <= vl - 2);
      end
    end
    req_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(done && !res_valid, "R10", "done after last result", {done, res_valid}, 64'b10);
    chk(illegal == 1'b0, "R11", "no late acceptance", 64'(illegal), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] x;
    x = 64'h1234_5678_9ABC_DEF1;
    for (int i = 0; i < 64; i++) begin
      x = x * 64'd6364136223846793005 + 64'd1442695040888963407;
      mem[i] = x ^ (x >> 29);
    end
    mem[0] = 64'h0807_FAF9_0605_FCFD;

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready && !res_valid && !done && !illegal, "R12", "reset state",
        {req_ready, res_valid, done, illegal}, 64'b1000);
    rst = 1'b0;

    for (int sg = 0; sg < 2; sg++)
      for (int f = 0; f < 4; f++)
        for (int s = 0; s < 4; s++)
          for (int l = 0; l < 8; l++)
            for (int p = 0; p < 5; p++) begin
              int vd, vs2;
              case (p)
                0: begin vd = 0;  vs2 = 0;  end
                1: begin vd = 8;  vs2 = 16; end
                2: begin vd = 6;  vs2 = 4;  end
                3: begin vd = 2;  vs2 = 1;  end
                default: begin vd = 3; vs2 = 2; end
              endcase
              run_case(sg[0], f, s, l, vd, vs2, 1 + ((sg + f + s + l + p) % 9), 1'b0);
            end

    for (int sg = 0; sg < 2; sg++)
      for (int f = 1; f < 4; f++) begin
        run_case(sg[0], f, 3, 3, 0, 0, MAX_VL, 1'b1);
        run_case(sg[0], f, 3, 3, 8, 0, 0, 1'b0);
        run_case(sg[0], f, 3, 0, 1, 0, 1, 1'b0);
      end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule